// File: doc/BRIEF.md
# Serial DAC Command Register Bank

This block sits behind a byte-wide register port, such as the parallel side of a two-wire bus slave. It lets a host build a 16-bit DAC control word one byte at a time and then send it. Two byte registers hold the word. Address 0 is the high byte and address 1 is the low byte. A third register at address 2 is the command register. Writing any value to the command register starts one serial frame to the DAC.

The block contains the serialiser because the command register must clear itself when the frame ends. At the start of a frame the word is copied into a shift register, so the host can write the byte registers while a frame is in flight. The bits leave most significant first, with an active-high frame strobe and a gated serial clock. The serial clock runs at the system clock divided by `CLK_DIV` and idles low. Data changes only after a falling edge of the serial clock, so the DAC can sample it on the rising edge.

While a frame is pending or in flight, the command register reads back a fixed nonzero code. It returns to zero in the cycle the frame strobe drops.

Top module: `dac_cmd_bank`

## Requirements
- R1: After a synchronous active-high reset, all three registers read 0, the held word is 0, and the frame strobe, serial clock, serial data, busy and start outputs are all 0.
- R2: A write to address 0 sets the high byte and a write to address 1 sets the low byte, from the next cycle on. The held word is {high byte, low byte}. The read port combinationally returns the register that the current address selects.
- R3: While idle, a write of any value (including 0) to address 2 raises `start_pulse` for exactly one cycle, in the cycle after the write. From that same cycle, `busy` is high and address 2 reads 8'h01.
- R4: The frame strobe rises in the cycle after `start_pulse`. It stays high for exactly 16*CLK_DIV cycles.
- R5: The 16 bits of the word present when the start pulse was high are sent MSB first. Each bit is held for CLK_DIV cycles, and serial data never changes while the serial clock is high or as it rises.
- R6: The serial clock is low whenever the frame strobe is low. Inside a frame it starts low and toggles every CLK_DIV/2 cycles.
- R7: In the cycle the frame strobe falls, `busy` falls and address 2 reads 0 again.
- R8: Writing the byte registers during a frame changes their read-back value and the held word, but does not change the bits of the frame in flight.
- R9: A write to address 2 while busy is ignored. It produces no start pulse and does not lengthen or restart the frame.
- R10: A write to address 3 changes no register, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | BYTE_W | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | BYTE_W | Read data for `reg_addr` (combinational) |
| word_out | output | WORD_W | Held control word {high, low} |
| start_pulse | output | 1 | One-cycle pulse when a frame is launched |
| busy | output | 1 | Frame pending or in flight |
| ser_data | output | 1 | Serial data to the DAC |
| ser_clk | output | 1 | Gated serial clock, idles low |
| ser_frame | output | 1 | Active-high frame strobe |

## Verification
A stuck command flag shows up on the port at once. The address-2 read-back and `busy` disagree with the model in the first cycle after the frame strobe falls. A wrong bit counter or phase counter shows in the strobe length or in the serial clock within one serial period. A shift register that reloads or shifts at the wrong moment shows in the very next compare of `ser_data`. It also shows in the word rebuilt by sampling on serial clock rising edges, which is compared when the frame ends. A start that is accepted while busy shows as an extra `start_pulse` in the same cycle.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
   // Code returned by the command register while a frame is pending or in flight.
   localparam int CMD_BUSY_CODE = 1;

   // Frame length in system clock cycles.
   function automatic int frame_cycles(input int word_w, input int clk_div);
      return word_w * clk_div;
   endfunction
endpackage

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs #(
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int BUSY_CODE = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              wr,
   input  logic              done,
   output logic [WORD_W-1:0] word,
   output logic              start,
   output logic              busy,
   output logic [BYTE_W-1:0] rdata
);
   localparam int NBYTES    = WORD_W / BYTE_W;
   localparam int LOAD_ADDR = NBYTES;

   logic [NBYTES-1:0][BYTE_W-1:0] byte_vec;
   logic load_q;
   logic start_q;
   logic accept;

   if (BUSY_CODE == 0) begin : g_bad_code
      $error("BUSY_CODE must be nonzero");
   end

   assign accept = wr && (int'(addr) == LOAD_ADDR) && !load_q;

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else if (wr && int'(addr) == k) q <= wdata;
      end
      assign byte_vec[k] = q;
      // byte 0 is the most significant byte of the word
      assign word[WORD_W-1-k*BYTE_W -: BYTE_W] = q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         load_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= accept;
         if (accept) load_q <= 1'b1;
         else if (done) load_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NBYTES; k++) begin
         if (int'(addr) == k) rdata = byte_vec[k];
      end
      if (int'(addr) == LOAD_ADDR) rdata = load_q ? BYTE_W'(BUSY_CODE) : '0;
   end

   assign start = start_q;
   assign busy  = load_q;

   // R9: a launch only comes out of an idle register
   p_start_from_idle_r9: assert property (@(posedge clk) disable iff (rst)
      start |-> (busy && !$past(busy)));
   // R7: completion from the serialiser clears the command register
   p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy);
   // R9: busy is not dropped by anything but completion
   p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> busy);
endmodule

// File: rtl/dac_cmd_serialiser.sv
module dac_cmd_serialiser #(
   parameter int WORD_W  = 16,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   output logic              frame,
   output logic              sclk,
   output logic              sdata,
   output logic              done
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int BIT_W = $clog2(WORD_W);

   logic              frame_q;
   logic              sclk_q;
   logic [WORD_W-1:0] shift_q;
   logic [BIT_W-1:0]  bit_q;
   logic              tick;
   logic              last_bit;

   assign last_bit = (bit_q == BIT_W'(WORD_W - 1));

   if (HALF == 1) begin : g_nodiv
      assign tick = frame_q;
   end else begin : g_div
      localparam int PH_W = $clog2(HALF);
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk) begin
         if (rst || !frame_q) ph_q <= '0;
         else if (ph_q == PH_W'(HALF - 1)) ph_q <= '0;
         else ph_q <= ph_q + 1'b1;
      end
      assign tick = frame_q && (ph_q == PH_W'(HALF - 1));
   end

   assign done = tick && sclk_q && last_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q <= 1'b0;
         sclk_q  <= 1'b0;
         shift_q <= '0;
         bit_q   <= '0;
      end else if (start && !frame_q) begin
         frame_q <= 1'b1;
         sclk_q  <= 1'b0;
         shift_q <= word;
         bit_q   <= '0;
      end else if (tick) begin
         sclk_q <= ~sclk_q;
         if (sclk_q) begin
            shift_q <= {shift_q[WORD_W-2:0], 1'b0};
            if (last_bit) begin
               frame_q <= 1'b0;
               bit_q   <= '0;
            end else begin
               bit_q <= bit_q + 1'b1;
            end
         end
      end
   end

   assign frame = frame_q;
   assign sclk  = sclk_q & frame_q;
   assign sdata = shift_q[WORD_W-1];

   // R6: no serial clock outside a frame
   p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !frame |-> !sclk);
   // R5: data is settled at the sampling edge
   p_data_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk) |-> $stable(sdata));
   // R5: data holds while the serial clock is high
   p_data_hold_high_r5: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk)) |-> $stable(sdata));
   // R4: the register bank never launches into a running frame
   p_start_idle_r4: assert property (@(posedge clk) disable iff (rst)
      start |-> !frame);
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank #(
   parameter int SYS_HZ      = 30_000_000,
   parameter int SCLK_MAX_HZ = 30_000_000,
   parameter int WORD_W      = 16,
   parameter int BYTE_W      = 8,
   parameter int CLK_DIV     = 2,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_wr,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic [WORD_W-1:0] word_out,
   output logic              start_pulse,
   output logic              busy,
   output logic              ser_data,
   output logic              ser_clk,
   output logic              ser_frame
);
   import dac_cmd_pkg::*;

   localparam int NBYTES   = WORD_W / BYTE_W;
   localparam int MIN_ADDR = $clog2(NBYTES + 1);
   localparam int FRAME_CY = frame_cycles(WORD_W, CLK_DIV);

   if (WORD_W % BYTE_W != 0 || NBYTES < 2) begin : g_bad_word
      $error("WORD_W must be a multiple of BYTE_W, at least two bytes");
   end
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (SYS_HZ / CLK_DIV > SCLK_MAX_HZ) begin : g_bad_rate
      $error("serial clock would exceed SCLK_MAX_HZ");
   end
   if (ADDR_W < MIN_ADDR) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (FRAME_CY < 2) begin : g_bad_frame
      $error("frame length too short");
   end

   logic done;

   dac_cmd_regs #(
      .BYTE_W(BYTE_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BUSY_CODE(CMD_BUSY_CODE)
   ) u_regs (
      .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
      .done(done), .word(word_out), .start(start_pulse), .busy(busy),
      .rdata(reg_rdata)
   );

   dac_cmd_serialiser #(
      .WORD_W(WORD_W), .CLK_DIV(CLK_DIV)
   ) u_ser (
      .clk(clk), .rst(rst), .start(start_pulse), .word(word_out),
      .frame(ser_frame), .sclk(ser_clk), .sdata(ser_data), .done(done)
   );

   // R4: the strobe follows the launch pulse by one cycle
   p_launch_frame_r4: assert property (@(posedge clk) disable iff (rst)
      start_pulse |=> ser_frame);
   // R7: a frame never runs outside the busy window
   p_frame_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
      ser_frame |-> busy);
   // R7: busy and strobe fall together
   p_end_together_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(ser_frame) |-> !busy);
endmodule

// File: tb/dac_cmd_bank_test.sv
module dac_cmd_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 2;
   localparam int HALF  = DIV / 2;
   localparam int FLEN  = 16 * DIV;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;
   logic [15:0] word_out;
   logic start_pulse, busy, ser_data, ser_clk, ser_frame;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   dac_cmd_bank uut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .word_out(word_out),
      .start_pulse(start_pulse), .busy(busy), .ser_data(ser_data),
      .ser_clk(ser_clk), .ser_frame(ser_frame)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced on each rising edge
   int m_hi = 0, m_lo = 0;
   bit m_busy = 0, m_start = 0;
   int m_t = -1;
   logic [15:0] m_word = '0;

   always @(posedge clk) begin
      int hi_old, lo_old;
      bit busy_old, start_old;
      hi_old = m_hi; lo_old = m_lo; busy_old = m_busy; start_old = m_start;
      if (rst) begin
         m_hi = 0; m_lo = 0; m_busy = 0; m_start = 0; m_t = -1; m_word = '0;
      end else begin
         if (m_t >= 0) begin
            m_t++;
            if (m_t == FLEN) begin
               m_t = -1;
               m_busy = 0;
            end
         end
         if (start_old) begin
            m_t = 0;
            m_word = 16'((hi_old << 8) | lo_old);
         end
         m_start = reg_wr && reg_addr == 2'd2 && !busy_old;
         if (m_start) m_busy = 1;
         if (reg_wr && reg_addr == 2'd0) m_hi = int'(reg_wdata);
         if (reg_wr && reg_addr == 2'd1) m_lo = int'(reg_wdata);
      end
   end

   // Compare every cycle, away from the active edge
   int start_seen = 0;
   always @(negedge clk) begin
      if (!rst) begin
         int exp_rd;
         bit fr;
         fr = (m_t >= 0);
         case (reg_addr)
            2'd0: exp_rd = m_hi;
            2'd1: exp_rd = m_lo;
            2'd2: exp_rd = m_busy ? 1 : 0;
            default: exp_rd = 0;
         endcase
         chk("R2", "rdata", int'(reg_rdata), exp_rd);
         chk("R2", "word_out", int'(word_out), (m_hi << 8) | m_lo);
         chk("R3", "start_pulse", int'(start_pulse), int'(m_start));
         chk("R7", "busy", int'(busy), int'(m_busy));
         chk("R4", "ser_frame", int'(ser_frame), int'(fr));
         chk("R6", "ser_clk", int'(ser_clk), fr ? ((m_t / HALF) % 2) : 0);
         chk("R5", "ser_data", int'(ser_data), fr ? int'(m_word[15 - m_t / DIV]) : 0);
         if (start_pulse) start_seen++;
      end
   end

   // Simple DAC receiver: samples on serial clock rising edges
   logic [15:0] rx = '0;
   always @(posedge ser_clk) rx = {rx[14:0], ser_data};

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output int v);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      v = int'(reg_rdata);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      int v, s0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      chk("R1", "frame after reset", int'(ser_frame), 0);
      chk("R1", "sclk after reset", int'(ser_clk), 0);
      chk("R1", "busy after reset", int'(busy), 0);
      chk("R1", "word after reset", int'(word_out), 0);
      rd_reg(2'd0, v); chk("R1", "hi after reset", v, 0);
      rd_reg(2'd1, v); chk("R1", "lo after reset", v, 0);
      rd_reg(2'd2, v); chk("R1", "load after reset", v, 0);

      // R2: byte registers
      wr_reg(2'd0, 8'hA5);
      wr_reg(2'd1, 8'h3C);
      rd_reg(2'd0, v); chk("R2", "hi readback", v, 'hA5);
      rd_reg(2'd1, v); chk("R2", "lo readback", v, 'h3C);

      // R3: write of zero still launches, R5: received word
      s0 = start_seen;
      wr_reg(2'd2, 8'h00);
      rd_reg(2'd2, v); chk("R3", "load reads nonzero while busy", v, 1);
      wait_idle();
      rd_reg(2'd2, v); chk("R7", "load cleared after frame", v, 0);
      chk("R5", "received word", int'(rx), 'hA53C);
      chk("R3", "one start for zero write", start_seen - s0, 1);

      // R8, R9: writes during a frame
      wr_reg(2'd0, 8'h81);
      wr_reg(2'd1, 8'h7E);
      s0 = start_seen;
      wr_reg(2'd2, 8'hFF);
      repeat (3) @(posedge clk);
      wr_reg(2'd0, 8'h12);
      wr_reg(2'd1, 8'h34);
      wr_reg(2'd2, 8'h5A);
      wait_idle();
      chk("R8", "frame unaffected by byte writes", int'(rx), 'h817E);
      rd_reg(2'd0, v); chk("R8", "hi updated during frame", v, 'h12);
      chk("R9", "load while busy ignored", start_seen - s0, 1);

      // R10: unmapped address
      wr_reg(2'd3, 8'h55);
      rd_reg(2'd3, v); chk("R10", "addr3 reads zero", v, 0);
      rd_reg(2'd0, v); chk("R10", "hi untouched", v, 'h12);
      rd_reg(2'd1, v); chk("R10", "lo untouched", v, 'h34);

      // Back-to-back frames with other patterns
      wr_reg(2'd2, 8'h01);
      wait_idle();
      chk("R5", "received 1234", int'(rx), 'h1234);
      wr_reg(2'd0, 8'h00);
      wr_reg(2'd1, 8'h01);
      wr_reg(2'd2, 8'h80);
      wait_idle();
      chk("R5", "received 0001", int'(rx), 'h0001);

      repeat (4) @(posedge clk);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule